// File: doc/BRIEF.md
# Keyed External Reset Pulse Generator

This block turns a single-cycle expiry strobe from a watchdog into a reset pulse of programmable length on an external line. The length is counted in microsecond ticks, derived from the system clock by a fixed cycle count per tick. A programmed width value N gives a pulse of N+1 ticks. A width of 0 therefore still gives one tick. The reset value of the width is 0xFF, which gives 256 ticks.

The line's active level and its drive style are held in the top two bits of one 32-bit configuration word. These two bits are guarded by key bytes. They move only when one of four exact values lands in the top byte of a write. Every write updates the width field, whatever top byte it carries. Open-drain operation is emulated with an output-enable that is raised only while the pulse is asserted. A busy flag covers the whole pulse. Any expiry strobe that arrives during a pulse is dropped.

Top module: `rpg_ext_reset`

## Requirements
- R1: Every configuration write loads bits 19:0 of the write data into the width field. The width field reads back on bits 19:0 in the cycle after the write.
- R2: After reset the readback word is 0x000000FF: width 0xFF, active-low and open-drain. After reset, busy is 0, pad_level is 1 and pad_oe is 0.
- R3: A write with top byte 0xA5 makes readback bit 31 equal to 1 (active high). A write with top byte 0x5A makes bit 31 equal to 0 (active low).
- R4: A write with top byte 0xA8 makes readback bit 30 equal to 1 (push-pull). A write with top byte 0x8A makes bit 30 equal to 0 (open drain).
- R5: A write with any other top byte leaves bits 31 and 30 unchanged. Readback bits 29:20 are always 0.
- R6: An expiry strobe while idle raises busy from the next cycle. Busy then stays high for exactly (N+1)*TICK_CYCLES clock cycles, where N is the width in effect at the strobe.
- R7: While busy, pad_level equals the active level given by bit 31. While idle, pad_level is the opposite level.
- R8: In open-drain mode (bit 30 = 0), pad_oe is high only while busy. In push-pull mode (bit 30 = 1), pad_oe is always high.
- R9: An expiry strobe that arrives while busy is high is ignored. This holds in the final cycle of a pulse too, and the running pulse keeps its length.
- R10: A width write made during a pulse does not change the length of that pulse. The next pulse uses the new width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data; key byte in bits 31:24, width in bits 19:0 |
| cfg_rdata | output | 32 | Configuration readback: bit 31 active-high, bit 30 push-pull, bits 19:0 width |
| expire | input | 1 | One-cycle watchdog expiry strobe |
| pad_level | output | 1 | Level presented to the external reset pad |
| pad_oe | output | 1 | Output enable for the pad; low means released |
| busy | output | 1 | High for the whole duration of a pulse |

## Verification
The key decoder is swept with all 256 top-byte values, each paired with a different width. This separates the four keys from every near miss, and shows that the width is taken on every write. Pulses are run for widths 0 to 5 under all four combinations of level and drive style. The sampled busy length, pad level and enable are checked in each combination, which exposes off-by-one tick counts and mixed-up polarity or enable terms. Further runs use the 0xFF reset width, a strobe in the middle of a pulse, a strobe in the final busy cycle, and a width rewrite in the middle of a pulse. These show that a pulse in progress can be neither restarted nor stretched.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  localparam int unsigned WIDTH_BITS = 20;
  localparam int unsigned REG_BITS   = 32;

  localparam logic [7:0] KEY_ACT_HIGH = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW  = 8'h5A;
  localparam logic [7:0] KEY_PUSHPULL = 8'hA8;
  localparam logic [7:0] KEY_OPENDRN  = 8'h8A;

  typedef logic [WIDTH_BITS-1:0] width_t;

  typedef struct packed {
    logic   act_high;
    logic   push_pull;
    width_t width;
  } cfg_t;

  // Guarded bit update: only exact key bytes move the bit.
  function automatic logic key_bit(logic cur, logic [7:0] key,
                                   logic [7:0] on_key, logic [7:0] off_key);
    if (key == on_key)  return 1'b1;
    if (key == off_key) return 1'b0;
    return cur;
  endfunction

  function automatic logic [REG_BITS-1:0] pack_readback(cfg_t c);
    return {c.act_high, c.push_pull, {(REG_BITS-2-WIDTH_BITS){1'b0}}, c.width};
  endfunction

  function automatic logic drive_level(logic act_high, logic asserted);
    return asserted ? act_high : ~act_high;
  endfunction
endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
  import rpg_pkg::*;
#(
  parameter int unsigned RESET_WIDTH = 255
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_BITS-1:0] wr_data,
  output cfg_t                cfg
);
  logic [7:0] key;
  logic [3:0] unused_gap;

  assign key        = wr_data[REG_BITS-1 -: 8];
  assign unused_gap = wr_data[REG_BITS-9 -: 4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.act_high  <= 1'b0;
      cfg.push_pull <= 1'b0;
      cfg.width     <= width_t'(RESET_WIDTH);
    end else if (wr_en) begin
      cfg.act_high  <= key_bit(cfg.act_high,  key, KEY_ACT_HIGH, KEY_ACT_LOW);
      cfg.push_pull <= key_bit(cfg.push_pull, key, KEY_PUSHPULL, KEY_OPENDRN);
      cfg.width     <= wr_data[WIDTH_BITS-1:0];
    end
  end
endmodule

// File: rtl/rpg_pulse_engine.sv
module rpg_pulse_engine
  import rpg_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 50
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   trig,
  input  width_t width,
  output logic   active,
  output logic   fire,
  output logic   last_tick
);
  localparam int unsigned DIV_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_CYCLES - 1);

  logic [DIV_W-1:0] div_cnt;
  width_t           remain;
  logic             tick;

  assign fire      = trig & ~active;
  assign tick      = active & (div_cnt == DIV_LAST);
  assign last_tick = tick & (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      remain  <= '0;
      div_cnt <= '0;
    end else if (fire) begin
      active  <= 1'b1;
      remain  <= width;
      div_cnt <= '0;
    end else if (active) begin
      if (tick) begin
        div_cnt <= '0;
        if (remain == '0) active <= 1'b0;
        else              remain <= remain - 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rpg_pad_drive.sv
module rpg_pad_drive
  import rpg_pkg::*;
(
  input  logic asserted,
  input  logic act_high,
  input  logic push_pull,
  output logic level,
  output logic oe
);
  assign level = drive_level(act_high, asserted);
  assign oe    = push_pull | asserted;
endmodule

// File: rtl/rpg_ext_reset.sv
module rpg_ext_reset
  import rpg_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 50,
  parameter int unsigned RESET_WIDTH = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        expire,
  output logic        pad_level,
  output logic        pad_oe,
  output logic        busy
);
  cfg_t cfg;
  logic pulse_on;
  logic pulse_fire;
  logic last_tick;

  rpg_cfg_reg #(.RESET_WIDTH(RESET_WIDTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_data(cfg_wdata), .cfg(cfg)
  );

  rpg_pulse_engine #(.TICK_CYCLES(TICK_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .trig(expire), .width(cfg.width),
    .active(pulse_on), .fire(pulse_fire), .last_tick(last_tick)
  );

  rpg_pad_drive u_pad (
    .asserted(pulse_on), .act_high(cfg.act_high), .push_pull(cfg.push_pull),
    .level(pad_level), .oe(pad_oe)
  );

  assign cfg_rdata = pack_readback(cfg);
  assign busy      = pulse_on;
endmodule

// File: rtl/rpg_ext_reset_chk.sv
module rpg_ext_reset_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr,
  input logic [7:0]  wtop,
  input logic [19:0] wlow,
  input logic        rd_pol,
  input logic        rd_drv,
  input logic [19:0] rd_width,
  input logic        expire,
  input logic        busy,
  input logic        pad_level,
  input logic        pad_oe,
  input logic        pulse_fire,
  input logic        last_tick
);
  p_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rd_width == $past(wlow));

  p_polkey_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wtop == 8'hA5) |=> rd_pol);

  p_drvkey_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wtop == 8'h8A) |=> !rd_drv);

  p_nokey_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wtop != 8'hA5 && wtop != 8'h5A) |=> $stable(rd_pol));

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(expire));

  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_tick));

  p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pad_level == rd_pol);

  p_od_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drv |-> pad_oe == busy);

  p_pp_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drv |-> pad_oe);

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && expire) |-> !pulse_fire);
endmodule

bind rpg_ext_reset rpg_ext_reset_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
  .wtop(cfg_wdata[31:24]), .wlow(cfg_wdata[19:0]),
  .rd_pol(cfg_rdata[31]), .rd_drv(cfg_rdata[30]), .rd_width(cfg_rdata[19:0]),
  .expire(expire), .busy(busy), .pad_level(pad_level), .pad_oe(pad_oe),
  .pulse_fire(pulse_fire), .last_tick(last_tick)
);

// File: tb/sim_rpg_ext_reset.sv
module sim_rpg_ext_reset;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        expire = 1'b0;
  logic        pad_level, pad_oe, busy;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic        mpol = 1'b0;
  logic        mdrv = 1'b0;
  logic [19:0] mwidth = 20'hFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpg_ext_reset #(.TICK_CYCLES(TICK), .RESET_WIDTH(255)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .expire(expire), .pad_level(pad_level),
    .pad_oe(pad_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word();
    return {mpol, mdrv, 10'b0, mwidth};
  endfunction

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    mwidth = d[19:0];
    if (d[31:24] == 8'hA5) mpol = 1'b1;
    else if (d[31:24] == 8'h5A) mpol = 1'b0;
    if (d[31:24] == 8'hA8) mdrv = 1'b1;
    else if (d[31:24] == 8'h8A) mdrv = 1'b0;
  endtask

  task automatic set_mode(input logic pol, input logic drv, input logic [19:0] w);
    do_write({pol ? 8'hA5 : 8'h5A, 4'h0, w});
    do_write({drv ? 8'hA8 : 8'h8A, 4'h0, w});
    chk(cfg_rdata == model_word(), "R3/R4 mode set", cfg_rdata, model_word());
  endtask

  // Runs one pulse; optional extra strobe and width rewrite at busy index.
  task automatic run_pulse(input int trig_at, input int wr_at,
                           input logic [19:0] new_w, input string tag);
    int cnt = 0;
    bit lvl_ok = 1;
    int exp_len = (int'(mwidth) + 1) * TICK;
    @(negedge clk);
    expire = 1'b1;
    @(negedge clk);
    expire = 1'b0;
    while (busy && cnt < 100000) begin
      if (pad_level !== mpol || pad_oe !== 1'b1) lvl_ok = 0;
      expire = (cnt == trig_at);
      cfg_wr = (cnt == wr_at);
      cfg_wdata = {8'h00, 4'h0, new_w};
      @(negedge clk);
      if (cfg_wr) mwidth = new_w;
      cfg_wr = 1'b0;
      cnt++;
    end
    expire = 1'b0;
    chk(cnt == exp_len, {tag, " R6/R9/R10 busy length"}, cnt, exp_len);
    chk(lvl_ok, {tag, " R7/R8 asserted pad"}, {pad_level, pad_oe}, {mpol, 1'b1});
    chk(pad_level == !mpol && pad_oe == mdrv, {tag, " R7/R8 idle pad"},
        {pad_level, pad_oe}, {!mpol, mdrv});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(cfg_rdata == 32'h000000FF, "R2 readback", cfg_rdata, 32'hFF);
    chk(busy == 1'b0, "R2 busy", busy, 0);
    chk(pad_level == 1'b1 && pad_oe == 1'b0, "R2 pad", {pad_level, pad_oe}, 2'b10);

    // R6 default width of 0xFF -> 256 ticks
    run_pulse(-1, -1, 20'h0, "default");

    // Sweep every top byte: R1 width, R3/R4 keys, R5 no-key
    for (int i = 0; i < 256; i++) begin
      logic [19:0] w;
      logic [7:0] k;
      k = 8'(i);
      w = 20'((i * 4099 + 17) ^ (i << 11));
      do_write({k, 4'hF, w});
      if (k == 8'hA5 || k == 8'h5A)
        chk(cfg_rdata == model_word(), "R3 R1 key write", cfg_rdata, model_word());
      else if (k == 8'hA8 || k == 8'h8A)
        chk(cfg_rdata == model_word(), "R4 R1 key write", cfg_rdata, model_word());
      else
        chk(cfg_rdata == model_word(), "R5 R1 non-key write", cfg_rdata, model_word());
    end

    // Pulse sweep over modes and small widths
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 6; w++) begin
        set_mode(m[0], m[1], 20'(w));
        run_pulse(-1, -1, 20'h0, "sweep");
      end
    end

    // R9: strobe mid-pulse and in the final busy cycle
    set_mode(1'b0, 1'b0, 20'd4);
    run_pulse(5, -1, 20'h0, "R9 mid");
    run_pulse(5 * TICK - 1, -1, 20'h0, "R9 last");

    // R10: width rewrite mid-pulse keeps this length, next uses new width
    set_mode(1'b1, 1'b1, 20'd3);
    begin
      int exp_len = 4 * TICK;
      int cnt = 0;
      @(negedge clk); expire = 1'b1;
      @(negedge clk); expire = 1'b0;
      while (busy && cnt < 1000) begin
        cfg_wr = (cnt == 2); cfg_wdata = 32'h0000_0001;
        @(negedge clk);
        cfg_wr = 1'b0;
        cnt++;
      end
      mwidth = 20'd1;
      chk(cnt == exp_len, "R10 current pulse unchanged", cnt, exp_len);
    end
    chk(cfg_rdata == model_word(), "R10 R5 rewrite kept mode", cfg_rdata, model_word());
    run_pulse(-1, -1, 20'h0, "R10 next");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule